// File: doc/BRIEF.md
# Sequential Floating-Point Fraction Divider

This block divides one floating-point word by another. Both words use the same layout: a sign bit, a characteristic that holds the exponent plus a bias, and an unsigned fraction. The two fractions are divided by a restoring divider that produces one quotient bit per clock. The characteristic of the result is the difference of the two characteristics. The bias cancels in that subtraction, so it is added back. The sign of the quotient follows the like/unlike rule.

A caller pulses `start` with both operands while the block is idle. Exactly one fraction-width of clocks later, `done` pulses and the quotient and remainder words are updated. If the divisor fraction is zero, or the dividend fraction is at least twice the divisor fraction, the quotient cannot be represented. In that case the block answers at once with `div_check` and leaves both result words as they were.

With the default parameters, a word is 36 bits wide. The fields are the sign in bit 35, an 8-bit characteristic in bits 34:27 with a bias of 128, and a 27-bit fraction in bits 26:0.

Top module: `fp_frac_divider`

## Requirements
- R1: Every word carries its sign in bit 35, its characteristic in bits 34:27 and its fraction in bits 26:0. A sign of 1 means negative.
- R2: A `start` accepted while idle, with a valid divisor, raises `done` for exactly one cycle. This happens 27 clock edges after the edge that accepted `start`.
- R3: When the dividend fraction a is smaller than the divisor fraction b, the quotient fraction is floor(a·2^27/b) and the remainder fraction is a·2^27 − q·b. The remainder is always smaller than b.
- R4: When b ≤ a < 2b, the dividend is first shifted right one place. The quotient fraction is then floor(a·2^26/b), the remainder fraction is a·2^26 − q·b, and the quotient characteristic is one higher.
- R5: The quotient characteristic is (dividend characteristic − divisor characteristic + 128), plus 1 in the R4 case, taken modulo 256.
- R6: The quotient sign is 0 when the operand signs are equal and 1 when they differ.
- R7: The remainder word takes its sign and its characteristic from the dividend.
- R8: If b is zero or a ≥ 2b, `done` and `div_check` rise together on the edge that accepts `start`. The quotient and remainder words keep their previous values.
- R9: `div_check` is 0 on every completion that produces a quotient.
- R10: A `start` pulse that arrives while a division is running is ignored. The running division finishes with its original operands.
- R11: After reset, `done`, `div_check`, `quotient` and `remainder` are all zero.
- R12: The quotient and remainder words change only on a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; only sampled while idle |
| dividend | input | 36 | Dividend word |
| divisor | input | 36 | Divisor word |
| done | output | 1 | One-cycle completion pulse |
| div_check | output | 1 | Quotient not representable; high together with `done` |
| quotient | output | 36 | Quotient word |
| remainder | output | 36 | Remainder word |

## Verification
The embedded properties take it for granted that the operand words only matter on the cycle when `start` is accepted. They also rely on the pre-alignment rejecting every case with a ≥ 2b, which keeps the partial remainder below the divisor after the first step. The stimulus sweeps a grid of fraction patterns: zero, one, all ones, the top bit alone, alternating bits, and near-equal pairs. Characteristics and signs change with each pair, so the equal, shifted, zero-divisor and too-large cases all occur. Every operation waits for its own completion before the next one starts, except for a deliberate extra `start` pulse sent during a running division.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fpd_state_e;
endpackage

// File: rtl/fpd_unpack.sv
module fpd_unpack #(
    parameter int CHAR_W = 8,
    parameter int FRAC_W = 27,
    localparam int WORD_W = 1 + CHAR_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic [CHAR_W-1:0] chr_o,
    output logic [FRAC_W-1:0] frac_o
);
    assign sign_o = word_i[WORD_W-1];
    assign chr_o  = word_i[WORD_W-2:FRAC_W];
    assign frac_o = word_i[FRAC_W-1:0];
endmodule

// File: rtl/fpd_align.sv
module fpd_align #(
    parameter int CHAR_W = 8,
    parameter int FRAC_W = 27
) (
    input  logic [FRAC_W-1:0] a_frac_i,
    input  logic [FRAC_W-1:0] b_frac_i,
    input  logic [CHAR_W-1:0] a_chr_i,
    input  logic [CHAR_W-1:0] b_chr_i,
    output logic              pre_shift_o,
    output logic              reject_o,
    output logic [CHAR_W-1:0] q_chr_o
);
    localparam logic [CHAR_W-1:0] BIAS = CHAR_W'(1) << (CHAR_W - 1);

    logic zero_div;
    logic too_big;

    always_comb begin
        zero_div    = (b_frac_i == '0);
        too_big     = ({1'b0, a_frac_i} >= {b_frac_i, 1'b0});
        reject_o    = zero_div | too_big;
        pre_shift_o = (a_frac_i >= b_frac_i);
        q_chr_o     = a_chr_i - b_chr_i + BIAS + CHAR_W'(pre_shift_o);
    end
endmodule

// File: rtl/fpd_step.sv
module fpd_step #(
    parameter int FRAC_W = 27
) (
    input  logic [FRAC_W-1:0] rem_i,
    input  logic [FRAC_W-1:0] div_i,
    input  logic              hold_i,
    output logic [FRAC_W-1:0] rem_o,
    output logic              qbit_o
);
    logic [FRAC_W:0] trial;
    logic [FRAC_W:0] diff;

    always_comb begin
        trial  = hold_i ? {1'b0, rem_i} : {rem_i, 1'b0};
        diff   = trial - {1'b0, div_i};
        qbit_o = (trial >= {1'b0, div_i});
        rem_o  = qbit_o ? diff[FRAC_W-1:0] : trial[FRAC_W-1:0];
    end
endmodule

// File: rtl/fp_frac_divider.sv
module fp_frac_divider #(
    parameter int CHAR_W = 8,
    parameter int FRAC_W = 27,
    localparam int WORD_W = 1 + CHAR_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] dividend,
    input  logic [WORD_W-1:0] divisor,
    output logic              done,
    output logic              div_check,
    output logic [WORD_W-1:0] quotient,
    output logic [WORD_W-1:0] remainder
);
    import fpd_pkg::*;

    localparam int CNT_W = $clog2(FRAC_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAC_W - 1);

    typedef struct packed {
        fpd_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] rem;
        logic [FRAC_W-1:0] dvs;
        logic [FRAC_W-1:0] qfrac;
        logic              pre;
        logic              q_sign;
        logic [CHAR_W-1:0] q_chr;
        logic              r_sign;
        logic [CHAR_W-1:0] r_chr;
        logic              done;
        logic              chk;
        logic [WORD_W-1:0] quo_out;
        logic [WORD_W-1:0] rem_out;
    } regs_t;

    regs_t r_q, r_d;

    logic              a_sign, b_sign;
    logic [CHAR_W-1:0] a_chr, b_chr;
    logic [FRAC_W-1:0] a_frac, b_frac;
    logic              pre_shift, reject;
    logic [CHAR_W-1:0] q_chr_new;
    logic [FRAC_W-1:0] rem_next;
    logic              qbit;
    logic              hold_first;

    fpd_unpack #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word_i(dividend), .sign_o(a_sign), .chr_o(a_chr), .frac_o(a_frac)
    );

    fpd_unpack #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word_i(divisor), .sign_o(b_sign), .chr_o(b_chr), .frac_o(b_frac)
    );

    fpd_align #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_align (
        .a_frac_i(a_frac), .b_frac_i(b_frac),
        .a_chr_i(a_chr), .b_chr_i(b_chr),
        .pre_shift_o(pre_shift), .reject_o(reject), .q_chr_o(q_chr_new)
    );

    assign hold_first = r_q.pre && (r_q.cnt == '0);

    fpd_step #(.FRAC_W(FRAC_W)) u_step (
        .rem_i(r_q.rem), .div_i(r_q.dvs), .hold_i(hold_first),
        .rem_o(rem_next), .qbit_o(qbit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.chk  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (reject) begin
                        r_d.done = 1'b1;
                        r_d.chk  = 1'b1;
                    end else begin
                        r_d.state  = ST_RUN;
                        r_d.cnt    = '0;
                        r_d.rem    = a_frac;
                        r_d.dvs    = b_frac;
                        r_d.qfrac  = '0;
                        r_d.pre    = pre_shift;
                        r_d.q_sign = a_sign ^ b_sign;
                        r_d.q_chr  = q_chr_new;
                        r_d.r_sign = a_sign;
                        r_d.r_chr  = a_chr;
                    end
                end
            end
            ST_RUN: begin
                r_d.qfrac = {r_q.qfrac[FRAC_W-2:0], qbit};
                r_d.rem   = rem_next;
                r_d.cnt   = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == LAST) begin
                    r_d.state   = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.quo_out = {r_q.q_sign, r_q.q_chr, r_q.qfrac[FRAC_W-2:0], qbit};
                    r_d.rem_out = {r_q.r_sign, r_q.r_chr, rem_next};
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign div_check = r_q.chk;
    assign quotient  = r_q.quo_out;
    assign remainder = r_q.rem_out;

    // R3
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && r_q.cnt != '0) |-> (r_q.rem < r_q.dvs));

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) |-> (r_q.cnt <= LAST));

    // R8
    check_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_check |-> done);

    // R8
    check_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_check |-> ($stable(quotient) && $stable(remainder)));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));

    // R10
    operands_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && $past(r_q.state == ST_RUN)) |-> $stable(r_q.dvs));

    // R3
    done_remainder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_check) |-> (remainder[FRAC_W-1:0] < r_q.dvs));
endmodule

// File: tb/fp_frac_divider_tb.sv
module fp_frac_divider_tb;
    localparam int CHAR_W = 8;
    localparam int FRAC_W = 27;
    localparam int WORD_W = 36;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [WORD_W-1:0] dividend = '0;
    logic [WORD_W-1:0] divisor = '0;
    logic              done;
    logic              div_check;
    logic [WORD_W-1:0] quotient;
    logic [WORD_W-1:0] remainder;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic finished = 1'b0;
    logic [WORD_W-1:0] exp_quo = '0;
    logic [WORD_W-1:0] exp_rem = '0;

    fp_frac_divider #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .done(done), .div_check(div_check),
        .quotient(quotient), .remainder(remainder)
    );

    always #5 clk = ~clk;

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [26:0] frac_pat(input int k);
        case (k)
            0: return 27'h0;
            1: return 27'h1;
            2: return 27'h4000000;
            3: return 27'h7FFFFFF;
            4: return 27'h4000001;
            5: return 27'h5555555;
            6: return 27'h2AAAAAA;
            7: return 27'h3;
            8: return 27'h6000000;
            default: return 27'h1234567;
        endcase
    endfunction

    // Issue one division; second_pulse sends an extra start mid-run (R10)
    task automatic run_op(input logic [WORD_W-1:0] a_w, input logic [WORD_W-1:0] b_w,
                          input logic second_pulse);
        logic [26:0] a, b;
        logic [63:0] num, q, r;
        logic        pre, bad;
        logic [7:0]  qc;
        int          lat;
        a   = a_w[26:0];
        b   = b_w[26:0];
        bad = (b == 0) || ({1'b0, a} >= {b, 1'b0});
        pre = (a >= b);
        @(negedge clk);
        dividend = a_w;
        divisor  = b_w;
        start    = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        dividend = ~a_w;
        divisor  = {b_w[35:27], 27'h0};
        lat = 0;
        @(negedge clk);
        while (!done && lat < 40) begin
            if (second_pulse && lat == 5) begin
                start    = 1'b1;
                dividend = {1'b1, 8'h11, 27'h0000007};
                divisor  = {1'b0, 8'h22, 27'h0000009};
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat = lat + 1;
        end
        start = 1'b0;
        if (bad) begin
            // R8: immediate answer, results unchanged
            check("R8 latency", 64'(lat), 64'd0);
            check("R8 div_check", 64'(div_check), 64'd1);
            check("R8 quotient held", 64'(quotient), 64'(exp_quo));
            check("R8 remainder held", 64'(remainder), 64'(exp_rem));
        end else begin
            num = pre ? (64'(a) << 26) : (64'(a) << 27);
            q   = num / 64'(b);
            r   = num % 64'(b);
            qc  = a_w[34:27] - b_w[34:27] + 8'd128 + 8'(pre);
            exp_quo = {a_w[35] ^ b_w[35], qc, q[26:0]};
            exp_rem = {a_w[35], a_w[34:27], r[26:0]};
            check(second_pulse ? "R10 latency" : "R2 latency", 64'(lat), 64'd27);
            check("R9 div_check low", 64'(div_check), 64'd0);
            check(pre ? "R4 quotient fraction" : "R3 quotient fraction",
                  64'(quotient[26:0]), 64'(q[26:0]));
            check("R5 characteristic", 64'(quotient[34:27]), 64'(qc));
            check("R6 sign", 64'(quotient[35]), 64'(a_w[35] ^ b_w[35]));
            check(pre ? "R4 remainder" : "R3 remainder", 64'(remainder[26:0]), 64'(r[26:0]));
            check("R7 remainder sign/char", 64'(remainder[35:27]), 64'(a_w[35:27]));
        end
        @(negedge clk);
        // R2 / R12: single pulse, results hold afterwards
        check("R2 done single cycle", 64'(done), 64'd0);
        check("R12 quotient holds", 64'(quotient), 64'(exp_quo));
        check("R12 remainder holds", 64'(remainder), 64'(exp_rem));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 done", 64'(done), 64'd0);
        check("R11 div_check", 64'(div_check), 64'd0);
        check("R11 quotient", 64'(quotient), 64'd0);
        check("R11 remainder", 64'(remainder), 64'd0);
        rst_n = 1'b1;
        // R1: field layout exercised by the sweep of signs, characteristics and fractions
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                logic [7:0] ea, eb;
                ea = 8'((i * 37 + 5 + j) & 255);
                eb = 8'((j * 53 + 100) & 255);
                run_op({1'(i & 1), ea, frac_pat(i)},
                       {1'((j ^ (i >> 1)) & 1), eb, frac_pat(j)}, 1'b0);
            end
        end
        // R10: extra start during a running division is ignored
        run_op({1'b1, 8'h90, 27'h5555555}, {1'b0, 8'h81, 27'h7000000}, 1'b1);
        run_op({1'b0, 8'h80, 27'h7FFFFFF}, {1'b1, 8'h80, 27'h7FFFFFF}, 1'b1);
        // R8 after a result, then a normal one
        run_op({1'b0, 8'h80, 27'h7FFFFFF}, {1'b0, 8'h80, 27'h3000000}, 1'b0);
        run_op({1'b1, 8'h00, 27'h0000001}, {1'b1, 8'hFF, 27'h4000000}, 1'b0);
        summary();
    end
endmodule